// File: doc/BRIEF.md
# DAC Output Clear Controller

This block chooses the 16-bit code that feeds the data register of a single-channel DAC. It sits after the serial input register. In normal running it forwards each code that a latch strobe delivers. It also keeps the last such code in a saved-code register. An asynchronous active-high clear input forces the output to a clear code. That code depends on the range type (unipolar voltage, bipolar voltage or current) and on a select term, which is the OR of a select pin and a select control bit. After clear is released, the output stays at the clear code. A later latch strobe that carries no new data puts back the code that was in use before the clear.

The same select rule gives a default code. The output takes the default code when the range changes, when the output enable rises, and for as long as the output enable is low. Two flags report whether the output is in the cleared/default state and whether it is disabled.

The latch strobe and the range-change strobe are plain control pins. They are not a valid/ready stream. The block always accepts them and has no back-pressure, so a strobe that arrives while clear is active is dropped and is not held for later.

Top module: `dac_clear_ctrl`

## Requirements
- R1: A high level on `clr_in` passes through a two-flop synchronizer. `dac_code` takes the clear code on the third rising clock edge after `clr_in` rises, and `held_flag` goes high.
- R2: The effective select is `sel_pin | sel_bit`. Either input alone gives the same clear code as both together.
- R3: `range_kind` 2'b00 means unipolar voltage and 2'b01 means bipolar voltage. For unipolar, select 0 gives 0x0000 and select 1 gives 0x8000. For bipolar, select 0 gives 0x8000 and select 1 gives 0x0000.
- R4: `range_kind` 2'b10 or 2'b11 means current output. Its clear and default code is 0x0000 for either select value.
- R5: After clear is released, `dac_code` keeps the clear code and `held_flag` stays high until a latch event.
- R6: A latch event is a high-to-low transition of `latch_n`. A latch event with `latch_new` low, in the held state, restores the saved code on the next edge and drops `held_flag`.
- R7: While the synchronized clear is high, a latch event with new data changes neither `dac_code` nor the saved code.
- R8: A one-cycle `range_chg` pulse, or a low-to-high change of `out_en`, drives the default code on the next edge and sets `held_flag`.
- R9: While `out_en` is low, `dac_code` follows the default code and `dis_flag` is high. A latch event with new data in this state updates only the saved code.
- R10: With clear low and the output enabled, a latch event with `latch_new` high puts `latch_code` on `dac_code` at the next edge and clears `held_flag`.
- R11: A latch event with new data after clear is released loads that code and replaces the saved code, so a later clear followed by a dataless latch restores the new code.
- R12: While `rst_n` is low, `dac_code` is 0x0000 and both `held_flag` and `dis_flag` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_in | input | 1 | Asynchronous active-high clear |
| sel_pin | input | 1 | Clear-select pin |
| sel_bit | input | 1 | Clear-select control bit |
| out_en | input | 1 | Output enable |
| range_kind | input | 2 | 00 unipolar V, 01 bipolar V, 1x current |
| range_chg | input | 1 | One-cycle pulse: a new range was selected |
| latch_n | input | 1 | Active-low latch strobe |
| latch_new | input | 1 | New data was shifted in before this latch |
| latch_code | input | 16 | Code from the input shift register |
| dac_code | output | 16 | Code for the DAC data register |
| held_flag | output | 1 | Output is in the cleared or default state |
| dis_flag | output | 1 | Output is disabled |

## Verification
The clear code is tried across all select combinations (pin only, bit only, neither) and all three range types. This shows that the select is an OR and that current mode ignores it. Clear cycles are combined with latch strobes with data and without data, before, during and after the clear. This tells the saved-code path apart from the live-data path, and shows that writes made during the clear are dropped. Range-change pulses and enable toggles, with a data latch made while disabled, separate the default path from the clear path.

// File: rtl/dcc_pkg.sv
`timescale 1ns/1ps
package dcc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_HELD = 2'b01,
    ST_DIS  = 2'b10
  } out_state_e;
endpackage

// File: rtl/dcc_sync.sv
`timescale 1ns/1ps
module dcc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_in};
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/dcc_strobe.sv
`timescale 1ns/1ps
module dcc_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_n,
  input  logic out_en,
  output logic latch_evt,
  output logic en_rise
);
  logic latch_q, en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b1;
      en_q    <= 1'b0;
    end else begin
      latch_q <= latch_n;
      en_q    <= out_en;
    end
  end

  // falling edge of the active-low latch, rising edge of the enable
  assign latch_evt = latch_q & ~latch_n;
  assign en_rise   = ~en_q & out_en;
endmodule

// File: rtl/dcc_target.sv
`timescale 1ns/1ps
module dcc_target #(
  parameter int CODE_W = 16
) (
  input  logic [1:0]        range_kind,
  input  logic              sel,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] MID  = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] ZERO = '0;

  always_comb begin
    unique case (range_kind)
      2'b00:   code = sel ? MID  : ZERO;   // unipolar: 0 V or midscale
      2'b01:   code = sel ? ZERO : MID;    // bipolar: 0 V is midscale
      default: code = ZERO;                // current: bottom of range
    endcase
  end
endmodule

// File: rtl/dac_clear_ctrl.sv
`timescale 1ns/1ps
module dac_clear_ctrl
  import dcc_pkg::*;
#(
  parameter int CODE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_in,
  input  logic              sel_pin,
  input  logic              sel_bit,
  input  logic              out_en,
  input  logic [1:0]        range_kind,
  input  logic              range_chg,
  input  logic              latch_n,
  input  logic              latch_new,
  input  logic [CODE_W-1:0] latch_code,
  output logic [CODE_W-1:0] dac_code,
  output logic              held_flag,
  output logic              dis_flag
);
  logic              clr_s;
  logic              latch_evt, en_rise;
  logic [CODE_W-1:0] tgt_code;
  logic [CODE_W-1:0] saved_code;
  out_state_e        state;
  logic              data_latch;

  dcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(clr_in), .d_out(clr_s)
  );

  dcc_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .latch_n(latch_n), .out_en(out_en),
    .latch_evt(latch_evt), .en_rise(en_rise)
  );

  dcc_target #(.CODE_W(CODE_W)) u_target (
    .range_kind(range_kind), .sel(sel_pin | sel_bit), .code(tgt_code)
  );

  assign data_latch = latch_evt & latch_new & ~clr_s;

  // saved code: only data latches taken while clear is low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          saved_code <= '0;
    else if (data_latch) saved_code <= latch_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_code <= '0;
      state    <= ST_DIS;
    end else if (clr_s) begin
      dac_code <= tgt_code;
      state    <= ST_HELD;
    end else if (!out_en) begin
      dac_code <= tgt_code;
      state    <= ST_DIS;
    end else if (en_rise || range_chg) begin
      dac_code <= tgt_code;
      state    <= ST_HELD;
    end else if (data_latch) begin
      dac_code <= latch_code;
      state    <= ST_RUN;
    end else if (latch_evt && state != ST_RUN) begin
      dac_code <= saved_code;
      state    <= ST_RUN;
    end
  end

  assign held_flag = (state != ST_RUN);
  assign dis_flag  = (state == ST_DIS);

  a_r1_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> held_flag);
  a_r7_saved_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> $stable(saved_code));
  a_r4_current_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && range_kind[1]) |=> (dac_code == '0));
  a_r9_disabled_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && !out_en) |=> dis_flag);
  a_r10_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_s && out_en && !en_rise && !range_chg && latch_evt && latch_new)
    |=> (dac_code == $past(latch_code) && !held_flag));
endmodule

// File: tb/sim_dac_clear_ctrl.sv
`timescale 1ns/1ps
module sim_dac_clear_ctrl;
  logic        clk = 0, rst_n = 0, clr_in = 0, sel_pin = 0, sel_bit = 0;
  logic        out_en = 1, range_chg = 0, latch_n = 1, latch_new = 0;
  logic [1:0]  range_kind = 2'b00;
  logic [15:0] latch_code = '0;
  logic [15:0] dac_code;
  logic        held_flag, dis_flag;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [17:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  dac_clear_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .clr_in(clr_in), .sel_pin(sel_pin),
    .sel_bit(sel_bit), .out_en(out_en), .range_kind(range_kind),
    .range_chg(range_chg), .latch_n(latch_n), .latch_new(latch_new),
    .latch_code(latch_code), .dac_code(dac_code),
    .held_flag(held_flag), .dis_flag(dis_flag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input logic [15:0] c, input logic h,
                            input logic d, input string tag);
    exp_q.push_back({c, h, d});
    tag_q.push_back(tag);
    #1;
  endtask

  task automatic pulse_latch(input logic nd, input logic [15:0] c);
    latch_n = 0; latch_new = nd; latch_code = c;
    tick(1);
    latch_n = 1; latch_new = 0;
  endtask

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      logic [17:0] e;
      string t;
      wait (exp_q.size() != 0);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({dac_code, held_flag, dis_flag} !== e) begin
        errors++;
        $display("FAIL %s: got code=%h held=%b dis=%b, expected code=%h held=%b dis=%b",
                 t, dac_code, held_flag, dis_flag, e[17:2], e[1], e[0]);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    expect_out(16'h0000, 1, 1, "R12 reset");
    rst_n = 1;
    tick(1);
    expect_out(16'h0000, 1, 0, "R8 enable rise after reset");
    pulse_latch(1, 16'h1234);
    expect_out(16'h1234, 0, 0, "R10 data latch");
    tick(1);
    // clear, unipolar select 0
    clr_in = 1; tick(2);
    expect_out(16'h1234, 0, 0, "R1 not yet through synchronizer");
    tick(1);
    expect_out(16'h0000, 1, 0, "R1 R3 unipolar sel0");
    pulse_latch(1, 16'hBEEF);
    expect_out(16'h0000, 1, 0, "R7 data latch ignored in clear");
    sel_pin = 1; tick(1);
    expect_out(16'h8000, 1, 0, "R2 R3 unipolar sel pin");
    range_kind = 2'b01; tick(1);
    expect_out(16'h0000, 1, 0, "R3 bipolar sel1");
    sel_pin = 0; sel_bit = 1; tick(1);
    expect_out(16'h0000, 1, 0, "R2 bipolar sel bit");
    sel_bit = 0; tick(1);
    expect_out(16'h8000, 1, 0, "R3 bipolar sel0");
    range_kind = 2'b10; tick(1);
    expect_out(16'h0000, 1, 0, "R4 current sel0");
    sel_pin = 1; sel_bit = 1; tick(1);
    expect_out(16'h0000, 1, 0, "R4 current sel1");
    range_kind = 2'b01; sel_pin = 0; sel_bit = 0; tick(1);
    expect_out(16'h8000, 1, 0, "R3 bipolar sel0 again");
    clr_in = 0; tick(8);
    expect_out(16'h8000, 1, 0, "R5 hold after release");
    pulse_latch(0, 16'hAAAA);
    expect_out(16'h1234, 0, 0, "R6 R7 dataless latch restores");
    tick(2);
    // data latch after release replaces the saved code
    clr_in = 1; tick(3); clr_in = 0; tick(3);
    pulse_latch(1, 16'h5555);
    expect_out(16'h5555, 0, 0, "R11 new data after release");
    clr_in = 1; tick(3);
    expect_out(16'h8000, 1, 0, "R1 second clear");
    clr_in = 0; tick(3);
    pulse_latch(0, 16'h0000);
    expect_out(16'h5555, 0, 0, "R11 restore replaced code");
    // range change
    range_chg = 1; tick(1); range_chg = 0;
    expect_out(16'h8000, 1, 0, "R8 range change default");
    pulse_latch(0, 16'h0000);
    expect_out(16'h5555, 0, 0, "R6 restore after range change");
    // disable
    range_kind = 2'b00; sel_bit = 1; out_en = 0; tick(1);
    expect_out(16'h8000, 1, 1, "R9 disabled default");
    pulse_latch(1, 16'h0F0F);
    expect_out(16'h8000, 1, 1, "R9 data latch while disabled");
    out_en = 1; tick(1);
    expect_out(16'h8000, 1, 0, "R8 enable rise");
    pulse_latch(0, 16'h0000);
    expect_out(16'h0F0F, 0, 0, "R9 code stored while disabled");

    wait (exp_q.size() == 0);
    #1;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule